// File: doc/BRIEF.md
# Output Rounding, Saturation and Format Stage

This stage sits at the end of a fixed-coefficient filter datapath. It takes the filter's wide signed accumulator result and turns it into a 16-bit output word. A 3-bit code chooses where the word's effective least significant bit lies, anywhere from bit 0 to bit 7. The stage rounds at that position, clears every bit beneath it, and clamps the rounded value to full scale when it no longer fits.

The clamped word can be passed on unchanged as two's complement, or converted to inverted offset binary by flipping every bit except the sign. A mode input moves the output binary point up by one place, which compensates for the halved amplitude of interpolation. The word is captured in an output register only when the upstream filter raises its output strobe. An active-low enable, which acts without waiting for the clock, either drives the register onto the pins or floats them.

Top module: `rsf_out_stage`

## Requirements
- R1: While reset is held and after it is released, the output register holds 0x0000, so that `data_out` reads 0x0000 while `oe_n` is low and no strobe has fired.
- R2: `rnd_sel` = k (0..7) sets the effective LSB at output bit k. Before truncation, one half of that LSB is added, so that exact halves round toward positive infinity.
- R3: When no clamp happens, output bits k-1 down to 0 are zero.
- R4: The limit is checked after the rounding addition. A rounded value above +32767 gives 0x7FFF, and one below -32768 gives 0x8000. A full-scale result keeps all its low bits, whatever the value of k.
- R5: With `interp_mode` = 0, output bit 0 weighs the same as accumulator bit GUARD (4 by default). With `interp_mode` = 1, it weighs the same as accumulator bit GUARD-1, so the output is doubled.
- R6: With `tc_fmt` = 1, the word is two's complement. With `tc_fmt` = 0, bits 14..0 are inverted and bit 15 is left unchanged.
- R7: The register loads the formatted word on a rising clock edge only when `out_stb` = 1. Otherwise it keeps its value, whatever the other inputs do.
- R8: With `oe_n` = 1, all 16 bits of `data_out` are high-impedance. With `oe_n` = 0, they carry the register. The change follows `oe_n` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_in | input | 24 | Signed accumulator result from the filter |
| rnd_sel | input | 3 | Effective LSB position code (0..7) |
| interp_mode | input | 1 | Moves the output binary point up one place |
| tc_fmt | input | 1 | 1 = two's complement, 0 = inverted offset binary |
| out_stb | input | 1 | Output register load strobe |
| oe_n | input | 1 | Active-low output enable, acts without a clock |
| data_out | output | 16 | Output word, or high-impedance |

## Verification
Rounding and saturation can fall in the same cycle. This happens when an input lies less than half an effective LSB below positive full scale, so that the added half-LSB carries past 0x7FFF. The bench applies such values for several rounding codes, in both modes and both formats. It expects 0x7FFF with its low bits still set, or the inverted form of that word, and never a wrapped negative word or a word with cleared low bits. Strongly negative inputs are checked the same way against 0x8000. Format conversion of a clamped word is judged in the same vectors.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int OUT_W = 16;
    localparam int SEL_W = 3;

    typedef logic [OUT_W-1:0] word_t;

    typedef struct packed {
        word_t word;
    } out_state_t;
endpackage

// File: rtl/rsf_round.sv
module rsf_round
    import rsf_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int GUARD = 4,
    localparam int SUM_W = ACC_W + 1,
    localparam int PW    = $clog2(GUARD + (1 << SEL_W)) + 1
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [SEL_W-1:0]        rnd_sel,
    input  logic                    interp_mode,
    output logic signed [SUM_W-1:0] scaled
);
    localparam logic [PW-1:0] BASE = PW'(GUARD);

    logic [PW-1:0]           pos;
    logic signed [SUM_W-1:0] acc_x;
    logic signed [SUM_W-1:0] half;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] trunc;

    always_comb begin
        pos   = (interp_mode ? BASE - PW'(1) : BASE) + PW'(rnd_sel);
        acc_x = {acc[ACC_W-1], acc};
        half  = {{(SUM_W-1){1'b0}}, 1'b1} << (pos - PW'(1));
        sum   = acc_x + half;
        trunc = sum >>> pos;
        scaled = trunc <<< rnd_sel;
    end

    initial begin
        assert (GUARD >= 2) else $error("GUARD must be at least 2");
    end
endmodule

// File: rtl/rsf_clamp.sv
module rsf_clamp
    import rsf_pkg::*;
#(
    parameter int IN_W = 25
) (
    input  logic signed [IN_W-1:0] val,
    output word_t                  word,
    output logic                   sat
);
    localparam logic signed [IN_W-1:0] MAX_V = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] MIN_V = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic hi, lo;

    always_comb begin
        hi  = val > MAX_V;
        lo  = val < MIN_V;
        sat = hi | lo;
        if (hi)
            word = {1'b0, {(OUT_W-1){1'b1}}};
        else if (lo)
            word = {1'b1, {(OUT_W-1){1'b0}}};
        else
            word = val[OUT_W-1:0];
    end
endmodule

// File: rtl/rsf_format.sv
module rsf_format
    import rsf_pkg::*;
(
    input  word_t in_word,
    input  logic  tc_fmt,
    output word_t out_word
);
    assign out_word[OUT_W-1] = in_word[OUT_W-1];

    for (genvar i = 0; i < OUT_W - 1; i++) begin : g_bit
        assign out_word[i] = tc_fmt ? in_word[i] : ~in_word[i];
    end
endmodule

// File: rtl/rsf_out_stage.sv
module rsf_out_stage
    import rsf_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int GUARD = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc_in,
    input  logic [SEL_W-1:0]        rnd_sel,
    input  logic                    interp_mode,
    input  logic                    tc_fmt,
    input  logic                    out_stb,
    input  logic                    oe_n,
    output logic [OUT_W-1:0]        data_out
);
    localparam int SUM_W = ACC_W + 1;

    logic signed [SUM_W-1:0] scaled;
    word_t                   clamp_word;
    logic                    clamp_sat;
    word_t                   fmt_word;
    out_state_t              st_d, st_q;

    rsf_round #(.ACC_W(ACC_W), .GUARD(GUARD)) u_round (
        .acc         (acc_in),
        .rnd_sel     (rnd_sel),
        .interp_mode (interp_mode),
        .scaled      (scaled)
    );

    rsf_clamp #(.IN_W(SUM_W)) u_clamp (
        .val  (scaled),
        .word (clamp_word),
        .sat  (clamp_sat)
    );

    rsf_format u_fmt (
        .in_word  (clamp_word),
        .tc_fmt   (tc_fmt),
        .out_word (fmt_word)
    );

    always_comb begin
        st_d = st_q;
        if (out_stb)
            st_d.word = fmt_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign data_out = oe_n ? {OUT_W{1'bz}} : st_q.word;

    // R3: below the chosen LSB nothing survives unless clamped
    p_low_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_sat |-> ((clamp_word & ~({OUT_W{1'b1}} << rnd_sel)) == '0));

    // R4: a clamp yields exactly one of the two full-scale words
    p_full_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_sat |-> (clamp_word == 16'h7FFF || clamp_word == 16'h8000));

    // R4: a clamp never flips the sign of the rounded value
    p_sat_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_sat |-> (clamp_word[OUT_W-1] == scaled[SUM_W-1]));

    // R6: sign bit passes through in both formats
    p_msb_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |=> st_q.word[OUT_W-1] == $past(clamp_word[OUT_W-1]));

    // R6: offset binary inverts the remaining bits
    p_obin_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && !tc_fmt) |=> st_q.word[OUT_W-2:0] == ~$past(clamp_word[OUT_W-2:0]));

    // R7: no strobe, no change
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_stb |=> $stable(st_q.word));
endmodule

// File: tb/rsf_out_stage_test.sv
module rsf_out_stage_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [23:0] acc_in = '0;
    logic [2:0]         rnd_sel = '0;
    logic               interp_mode = 1'b0;
    logic               tc_fmt = 1'b1;
    logic               out_stb = 1'b0;
    logic               oe_n = 1'b0;
    logic [15:0]        data_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rsf_out_stage uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_in      (acc_in),
        .rnd_sel     (rnd_sel),
        .interp_mode (interp_mode),
        .tc_fmt      (tc_fmt),
        .out_stb     (out_stb),
        .oe_n        (oe_n),
        .data_out    (data_out)
    );

    function automatic logic [15:0] expect_word(longint acc, int k, bit tc, bit itp);
        int     lsb_pos;
        longint s, q;
        logic [15:0] w;
        lsb_pos = (itp ? 3 : 4) + k;                 // R5 weight, R2 position
        s = acc + (64'sd1 <<< (lsb_pos - 1));        // R2 half-LSB
        q = (s >>> lsb_pos) <<< k;                   // R3 cleared bits
        if (q > 32767)       w = 16'h7FFF;           // R4
        else if (q < -32768) w = 16'h8000;
        else                 w = q[15:0];
        return tc ? w : {w[15], ~w[14:0]};           // R6
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply(longint acc, int k, bit tc, bit itp, string req);
        @(negedge clk);
        acc_in = 24'(acc); rnd_sel = 3'(k); tc_fmt = tc; interp_mode = itp; out_stb = 1'b1;
        @(negedge clk);
        out_stb = 1'b0;
        check(req, data_out, expect_word(acc, k, tc, itp));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset", data_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", data_out, 16'h0000);
    endtask

    task automatic t_sweep();
        longint vals[6] = '{24'sd1000, -24'sd1000, 24'sd123457, -24'sd98765, 24'sd8, -24'sd8};
        for (int k = 0; k < 8; k++)
            for (int t = 0; t < 2; t++)
                for (int v = 0; v < 6; v++)
                    apply(vals[v], k, bit'(t), 1'b0, "R2/R3/R6 sweep");
    endtask

    task automatic t_interp();
        for (int k = 0; k < 8; k += 3) begin
            apply(24'sd5000, k, 1'b1, 1'b1, "R5 interp pos");
            apply(-24'sd7777, k, 1'b0, 1'b1, "R5 interp neg");
        end
        apply(24'sd100, 0, 1'b1, 1'b1, "R5 doubled");   // 100/8 -> 12.5 -> 13
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 8; k++) begin
            // just below +full scale, carry of the half-LSB crosses 0x7FFF
            apply((64'sd32767 <<< 4) + 8, k, 1'b1, 1'b0, "R4 round-carry clamp");
            apply((64'sd32768 <<< 4) - (64'sd1 <<< (k + 3)), k, 1'b0, 1'b0, "R4 edge obin");
            apply(-(64'sd1 <<< 23), k, bit'(k[0]), 1'b0, "R4 neg clamp");
            apply((64'sd32767 <<< 3) + 4, k, bit'(k[1]), 1'b1, "R4 interp clamp");
        end
        apply((64'sd32767 <<< 4) + 8, 5, 1'b1, 1'b0, "R4 low bits kept");
        check("R4 explicit 7FFF", data_out, 16'h7FFF);
        apply(-(64'sd32768 <<< 4) - 9, 0, 1'b1, 1'b0, "R4 below min");
        check("R4 explicit 8000", data_out, 16'h8000);
        apply(-24'sd8, 0, 1'b1, 1'b0, "R2 half rounds up");
        check("R2 -0.5 to zero", data_out, 16'h0000);
    endtask

    task automatic t_hold();
        logic [15:0] held;
        apply(24'sd4242, 2, 1'b1, 1'b0, "R7 load");
        held = data_out;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            acc_in = 24'(-3000 * (i + 1)); rnd_sel = 3'(i); tc_fmt = i[0]; interp_mode = ~i[0];
            @(negedge clk);
            check("R7 hold", data_out, held);
        end
    endtask

    task automatic t_enable();
        logic [15:0] held;
        apply(24'sd31415, 1, 1'b0, 1'b0, "R8 setup");
        held = data_out;
        #1 oe_n = 1'b1;
        #1 check("R8 high-z", data_out, 16'hzzzz);
        #1 oe_n = 1'b0;
        #1 check("R8 driven", data_out, held);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_interp();
        t_saturate();
        t_hold();
        t_enable();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog got=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule